// File: doc/BRIEF.md
# PRBS-7 Link Self-Test Checker

This block checks the receive side of an at-speed link self test. Recovered 24-bit payload words arrive with a valid strobe. While the test enable is high, the block compares each word against a PRBS-7 reference that it seeds from the first word it receives. Each word that disagrees in any bit gives a short low pulse on the pass output. An external counter can count these pulses to estimate the payload error rate. The block also keeps its own saturating count of errored words.

When the enable falls, the pass output holds the verdict of the test: high if every checked word matched, low if any word did not. The verdict stays until the next test starts or the block is reset. During the test the parallel data output shows a checkerboard pattern instead of the received data. A matching PRBS-7 word generator is built in, so the link can be tested in loopback.

The short pulse is half a clock period long. A second clock at twice the word rate, phase aligned to the word clock, times it, so no logic uses a gated clock.

Top module: `prbs7_bist_checker`

## Requirements
- R1: The reference sequence follows x^7 + x^6 + 1, with b[n] = b[n-6] xor b[n-7]. It is packed 24 bits per word, and the earliest bit goes to bit 23. The first valid word after the enable rises is not checked. Its bits 6:0 (bit 0 newest) seed the reference, and each later valid word is compared against the next 24 bits of the sequence.
- R2: A checked word that differs from the reference in 1 to 24 bits drives pass_o low from the sampling clk_i edge until the next clk2x_i edge, which is half a word clock. Each errored word gives its own pulse, and back-to-back errored words give back-to-back pulses.
- R3: While the enable is high, pass_o is high on every cycle that has no errored word. A word sampled with valid low is neither checked nor counted.
- R4: While the enable is low, pass_o is 0 if the most recent test saw an errored word and 1 otherwise. This value holds until a new test starts or the block is reset.
- R5: The clk_i edge at which the enable is first sampled high clears the verdict and the error count.
- R6: During a test, each valid word makes data_o show 0xAAAAAA one edge later, then 0x555555, alternating from there. Outside a test, data_o captures data_i on each valid word. In both cases data_o holds its value when valid is low.
- R7: err_cnt_o counts the errored words of the current test and saturates at 2^CNT_W-1 (0xFFFF by default).
- R8: Each clk_i edge with gen_req_i high loads the next word of the generator sequence into gen_data_o and sets gen_valid_o. The sequence is seeded with 7'h01 at reset. Looping gen_data_o/gen_valid_o back into the checker gives no errors.
- R9: While rst_ni is low, pass_o is 1, and data_o, err_cnt_o and gen_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| clk2x_i | input | 1 | Double-rate clock, rising edges aligned with clk_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bist_en_i | input | 1 | Test window enable |
| valid_i | input | 1 | Payload word strobe |
| data_i | input | 24 | Recovered payload word |
| gen_req_i | input | 1 | Advance the built-in generator |
| pass_o | output | 1 | Error pulses during the test, verdict afterwards |
| data_o | output | 24 | Checkerboard during the test, received data otherwise |
| err_cnt_o | output | 16 | Saturating count of errored words |
| gen_valid_o | output | 1 | Generator word valid |
| gen_data_o | output | 24 | Generator word |

## Verification
An error pulse begins at the same clk_i edge that samples the errored word and ends at the next clk2x_i edge. The bench therefore looks for pass_o low 2 ns after that edge and high again 6 ns after it. data_o, err_cnt_o, the verdict and the generator outputs all change at the edge that samples their cause, so each check is made in the cycle that follows that edge. The bench drives inputs 7 ns after an edge, well clear of both clocks. Reset acts asynchronously and is checked while it is asserted.

// File: rtl/prbs7_bist_pkg.sv
package prbs7_bist_pkg;
  localparam int unsigned PRBS_ORD = 7;
  typedef logic [PRBS_ORD-1:0] prbs_state_t;
  typedef enum logic {CB_A = 1'b0, CB_B = 1'b1} cb_phase_e;
endpackage

// File: rtl/prbs7_step.sv
module prbs7_step #(
  parameter int unsigned W = 24
) (
  input  prbs7_bist_pkg::prbs_state_t state_i,
  output logic [W-1:0]                word_o
);
  // state_i[0] newest bit; word_o[W-1] earliest generated bit
  always_comb begin
    logic [6:0] s;
    logic       b;
    s      = state_i;
    word_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      b         = s[6] ^ s[5];
      word_o[i] = b;
      s         = {s[5:0], b};
    end
  end
endmodule

// File: rtl/prbs7_word_gen.sv
module prbs7_word_gen #(
  parameter int unsigned W    = 24,
  parameter logic [6:0]  SEED = 7'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  import prbs7_bist_pkg::*;

  prbs_state_t  state_q;
  logic [W-1:0] nxt_word;

  prbs7_step #(.W(W)) u_step (.state_i(state_q), .word_o(nxt_word));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        data_o  <= nxt_word;
        state_q <= nxt_word[PRBS_ORD-1:0];
      end
    end
  end

  a_r8_gen_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
endmodule

// File: rtl/bist_half_pulse.sv
module bist_half_pulse (
  input  logic clk2x_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic pulse_o
);
  logic tog_d_q;

  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) tog_d_q <= 1'b0;
    else         tog_d_q <= tog_i;
  end

  // high from a toggle until the next double-rate edge
  assign pulse_o = tog_i ^ tog_d_q;

  a_r2_half_pulse: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/bist_err_counter.sv
module bist_err_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/prbs7_bist_checker.sv
module prbs7_bist_checker #(
  parameter int unsigned W        = 24,
  parameter int unsigned CNT_W    = 16,
  parameter bit          HAS_GEN  = 1'b1,
  parameter logic [6:0]  GEN_SEED = 7'h01
) (
  input  logic             clk_i,
  input  logic             clk2x_i,
  input  logic             rst_ni,
  input  logic             bist_en_i,
  input  logic             valid_i,
  input  logic [W-1:0]     data_i,
  input  logic             gen_req_i,
  output logic             pass_o,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             gen_valid_o,
  output logic [W-1:0]     gen_data_o
);
  import prbs7_bist_pkg::*;

  logic [W-1:0] cb_a_w, cb_b_w;
  for (genvar i = 0; i < W; i++) begin : g_cb
    assign cb_a_w[i] = 1'(i % 2);
  end
  assign cb_b_w = ~cb_a_w;

  logic         en_q, seeded_q, fail_q, err_tog_q, pulse;
  cb_phase_e    cb_q;
  prbs_state_t  ref_state_q;
  logic [W-1:0] ref_word;
  logic         start, hit;

  prbs7_step #(.W(W)) u_ref (.state_i(ref_state_q), .word_o(ref_word));

  assign start = bist_en_i && !en_q;
  assign hit   = bist_en_i && valid_i && seeded_q && (data_i != ref_word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      seeded_q    <= 1'b0;
      ref_state_q <= '0;
      fail_q      <= 1'b0;
      err_tog_q   <= 1'b0;
    end else begin
      en_q <= bist_en_i;
      if (!bist_en_i) begin
        seeded_q <= 1'b0;
      end else if (valid_i) begin
        seeded_q    <= 1'b1;
        ref_state_q <= seeded_q ? ref_word[PRBS_ORD-1:0] : data_i[PRBS_ORD-1:0];
      end
      if (start)    fail_q    <= 1'b0;
      else if (hit) fail_q    <= 1'b1;
      if (hit)      err_tog_q <= ~err_tog_q;
    end
  end

  // output word: checkerboard during the test, captured data otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cb_q   <= CB_A;
      data_o <= '0;
    end else if (bist_en_i && valid_i) begin
      data_o <= (start || cb_q == CB_A) ? cb_a_w : cb_b_w;
      cb_q   <= (start || cb_q == CB_A) ? CB_B : CB_A;
    end else if (start) begin
      cb_q <= CB_A;
    end else if (valid_i && !bist_en_i) begin
      data_o <= data_i;
    end
  end

  bist_half_pulse u_pulse (
    .clk2x_i (clk2x_i),
    .rst_ni  (rst_ni),
    .tog_i   (err_tog_q),
    .pulse_o (pulse)
  );

  bist_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .inc_i  (hit),
    .cnt_o  (err_cnt_o)
  );

  assign pass_o = bist_en_i ? !pulse : !fail_q;

  if (HAS_GEN) begin : g_gen
    prbs7_word_gen #(.W(W), .SEED(GEN_SEED)) u_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (gen_req_i),
      .valid_o (gen_valid_o),
      .data_o  (gen_data_o)
    );
  end else begin : g_no_gen
    assign gen_valid_o = 1'b0;
    assign gen_data_o  = '0;
  end

  a_r4_verdict_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bist_en_i |=> $stable(fail_q));
  a_r5_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (err_cnt_o == '0 && !fail_q));
  a_r6_checkerboard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bist_en_i && valid_i) |=> (data_o == cb_a_w || data_o == cb_b_w));
  a_r1_no_check_unseeded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bist_en_i && !en_q) |=> err_tog_q == $past(err_tog_q));
endmodule

// File: tb/prbs7_bist_checker_tb.sv
module prbs7_bist_checker_tb;
  localparam int W  = 24;
  localparam int CW = 16;
  localparam logic [6:0] SEED = 7'h01;
  localparam int NV = 12;
  // {valid, corruption mask}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 24'h000000}, {1'b1, 24'h000000}, {1'b0, 24'hABCDEF},
    {1'b1, 24'h000001}, {1'b1, 24'h000000}, {1'b1, 24'hFFFFFF},
    {1'b1, 24'h800000}, {1'b1, 24'h010000}, {1'b0, 24'h000000},
    {1'b1, 24'h000000}, {1'b1, 24'h000000}, {1'b1, 24'h000100}};

  logic clk_i = 1'b1, clk2x_i = 1'b1, rst_ni = 1'b0;
  logic bist_en = 1'b0, valid_t = 1'b0, gen_req = 1'b0, lb = 1'b0;
  logic [W-1:0] data_t = '0;
  logic          pass_o, gen_valid_o, valid_w;
  logic [W-1:0]  data_o, gen_data_o, data_w;
  logic [CW-1:0] err_cnt_o;

  assign valid_w = lb ? gen_valid_o : valid_t;
  assign data_w  = lb ? gen_data_o  : data_t;

  always #4 clk_i   = ~clk_i;
  always #2 clk2x_i = ~clk2x_i;

  prbs7_bist_checker #(.W(W), .CNT_W(CW), .HAS_GEN(1'b1), .GEN_SEED(SEED)) u_dut (
    .clk_i(clk_i), .clk2x_i(clk2x_i), .rst_ni(rst_ni), .bist_en_i(bist_en),
    .valid_i(valid_w), .data_i(data_w), .gen_req_i(gen_req), .pass_o(pass_o),
    .data_o(data_o), .err_cnt_o(err_cnt_o), .gen_valid_o(gen_valid_o),
    .gen_data_o(gen_data_o));

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] words [128];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // reference stream b[n] = b[n-6]^b[n-7], earliest bit into the word MSB
  task automatic build_words();
    logic b [7 + 24*128];
    for (int j = 0; j < 7; j++) b[j] = SEED[6-j];
    for (int n = 7; n < 7 + 24*128; n++) b[n] = b[n-6] ^ b[n-7];
    for (int k = 0; k < 128; k++)
      for (int i = 0; i < W; i++) words[k][W-1-i] = b[7 + 24*k + i];
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int widx, nerr;
    bit cb;
    logic [W-1:0] prev;
    build_words();
    #20;
    chk(pass_o == 1'b1, "R9 pass_o in reset", 32'(pass_o), 1);
    chk(data_o == '0, "R9 data_o in reset", 32'(data_o), 0);
    chk(err_cnt_o == '0, "R9 err_cnt_o in reset", 32'(err_cnt_o), 0);
    chk(gen_valid_o == 1'b0, "R9 gen_valid_o in reset", 32'(gen_valid_o), 0);
    #3 rst_ni = 1'b1;
    @(posedge clk_i); #7;

    // Test 1: vector table during a test window (R1 R2 R3 R6)
    bist_en = 1'b1; widx = 0; nerr = 0; cb = 1'b0; prev = data_o;
    for (int i = 0; i < NV; i++) begin
      bit v, e;
      v = VEC[i][24];
      valid_t = v;
      data_t  = words[widx] ^ VEC[i][23:0];
      e = v && widx != 0 && VEC[i][23:0] != '0;
      @(posedge clk_i); #2;
      chk(pass_o == !e, e ? "R2 pulse low on errored word" : "R3 pass_o high / R1 seed unchecked",
          32'(pass_o), 32'(!e));
      if (v) begin
        chk(data_o == (cb ? 24'h555555 : 24'hAAAAAA), "R6 checkerboard", 32'(data_o),
            cb ? 32'h555555 : 32'hAAAAAA);
        cb = !cb; widx++;
      end else begin
        chk(data_o == prev, "R6 hold on invalid", 32'(data_o), 32'(prev));
      end
      prev = data_o;
      if (e) nerr++;
      #4;
      chk(pass_o == 1'b1, "R2 pulse ends after half period", 32'(pass_o), 1);
      #1;
    end
    bist_en = 1'b0; valid_t = 1'b0;
    @(posedge clk_i); #2;
    chk(pass_o == 1'b0, "R4 fail verdict", 32'(pass_o), 0);
    chk(err_cnt_o == CW'(nerr), "R7 error count", 32'(err_cnt_o), 32'(nerr));
    repeat (3) @(posedge clk_i);
    #2 chk(pass_o == 1'b0, "R4 fail verdict held", 32'(pass_o), 0);
    #5;

    // Test 2: clean test seeded mid-sequence (R1 R3 R5)
    bist_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      valid_t = 1'b1; data_t = words[20 + k];
      @(posedge clk_i); #2;
      if (k == 0) chk(err_cnt_o == '0, "R5 count cleared at start", 32'(err_cnt_o), 0);
      chk(pass_o == 1'b1, "R1 R3 clean sequence", 32'(pass_o), 1);
      #5;
    end
    bist_en = 1'b0; valid_t = 1'b0;
    @(posedge clk_i); #2;
    chk(pass_o == 1'b1, "R4 R5 pass verdict after clean test", 32'(pass_o), 1);
    chk(err_cnt_o == '0, "R5 count stays clear", 32'(err_cnt_o), 0);
    #5;

    // Test 3: passthrough outside a test (R6)
    valid_t = 1'b1; data_t = 24'h123456;
    @(posedge clk_i); #2;
    chk(data_o == 24'h123456, "R6 passthrough", 32'(data_o), 32'h123456);
    #5 valid_t = 1'b0; data_t = 24'h0F0F0F;
    @(posedge clk_i); #2;
    chk(data_o == 24'h123456, "R6 passthrough hold", 32'(data_o), 32'h123456);
    #5;

    // Test 4: generator loopback (R8)
    lb = 1'b1; bist_en = 1'b1; gen_req = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk_i); #2;
      chk(gen_valid_o == 1'b1, "R8 gen_valid_o", 32'(gen_valid_o), 1);
      chk(gen_data_o == words[k], "R8 gen word", 32'(gen_data_o), 32'(words[k]));
      chk(pass_o == 1'b1, "R8 loopback clean", 32'(pass_o), 1);
      #5;
    end
    gen_req = 1'b0; bist_en = 1'b0;
    @(posedge clk_i); #2;
    chk(pass_o == 1'b1 && err_cnt_o == '0, "R8 loopback verdict", {pass_o, 15'd0, err_cnt_o}, 32'h80000000);
    #5 lb = 1'b0;

    // Test 5: counter saturation (R7)
    bist_en = 1'b1; valid_t = 1'b1; data_t = words[0];
    @(posedge clk_i); #7;
    for (int k = 1; k <= 65540; k++) begin
      data_t = words[k % 127] ^ 24'h000001;
      @(posedge clk_i); #7;
    end
    bist_en = 1'b0; valid_t = 1'b0;
    @(posedge clk_i); #2;
    chk(err_cnt_o == 16'hFFFF, "R7 saturation", 32'(err_cnt_o), 32'hFFFF);
    chk(pass_o == 1'b0, "R4 fail verdict after saturation", 32'(pass_o), 0);
    #5;

    // Reset clears a held fail verdict (R9)
    rst_ni = 1'b0; #2;
    chk(pass_o == 1'b1, "R9 pass_o after reset", 32'(pass_o), 1);
    chk(err_cnt_o == '0, "R9 count after reset", 32'(err_cnt_o), 0);
    chk(data_o == '0, "R9 data_o after reset", 32'(data_o), 0);
    summary();
    $finish;
  end
endmodule